// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns queued characters into asynchronous serial frames on one output line. A host pushes characters with a one-cycle write strobe and watches a full flag. The block pulls characters from its queue one at a time and shifts each one out as a frame. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line sits high between frames.

Run-time control inputs set the frame shape:
- the data width, five to eight bits, chosen by a 2-bit code;
- whether a parity bit is sent, and whether it is even, odd or a fixed constant;
- one or two stop bits;
- whether the queue is a sixteen-entry FIFO or a single holding register.

A one-cycle tick from an outside rate generator paces the line. Each bit lasts sixteen ticks. An enable input stops new frames from starting. It never cuts off a frame that is already on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. Each frame begins with a start bit at 0. The data bits then follow with bit 0 first.
- R2: `cfg_wlen` sets the number of data bits: code 0 sends 5 bits, 1 sends 6, 2 sends 7 and 3 sends 8. Character bits at or above that count never reach the line.
- R3: When `cfg_par_en` is 1, one parity bit follows the last data bit. With `cfg_even` at 1, the data bits plus the parity bit hold an even number of ones. With `cfg_even` at 0 they hold an odd number. When `cfg_par_en` is 0, no parity bit is sent.
- R4: When `cfg_stick` and `cfg_par_en` are both 1, the parity bit equals the inverse of `cfg_even`. When `cfg_par_en` is 0, `cfg_stick` changes nothing on the line.
- R5: With `cfg_two_stop` at 1, each frame ends with two stop bits at 1. Otherwise it ends with one stop bit. The total frame length is (1 + data bits + parity bits + stop bits) × 16 ticks.
- R6: Each bit lasts 16 `baud_tick` pulses. `txd` changes only on the cycle after a tick, or on the cycle a frame starts.
- R7: The configuration inputs are captured when a frame starts. Changing them during the frame has no effect on that frame.
- R8: With `cfg_fifo_en` at 1, the queue holds up to 16 characters. `full` is 1 when 16 are held. A write while `full` is 1 is dropped. Characters leave the queue in the order they were written.
- R9: With `cfg_fifo_en` at 0, the queue holds one character. `full` is 1 while that character waits. A write while `full` is 1 is dropped.
- R10: While `en` is 0, no new frame starts. A frame in progress when `en` falls is sent to its last stop bit.
- R11: `busy` is 1 from the cycle the start bit begins until the last stop bit ends, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new frames to start |
| baud_tick | input | 1 | One-cycle pulse; 16 pulses make one bit |
| wr_en | input | 1 | Write strobe that pushes `wr_data` |
| wr_data | input | 8 | Character to queue |
| cfg_wlen | input | 2 | Data width code (0 to 3 gives 5 to 8 bits) |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Fixed-value parity select |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_fifo_en | input | 1 | 1: 16-entry FIFO, 0: one-character holding register |
| full | output | 1 | Queue cannot take a write |
| busy | output | 1 | A frame is on the line |
| txd | output | 1 | Serial output, high when idle |

## Verification
The hardest situations to reach are the ones where control inputs change while a frame is under way. These are changing the configuration after the start bit, and dropping the enable in mid-character with a second character already queued. The bench waits until it sees the start bit on `txd`, then changes the controls. It then decodes the rest of the frame against the settings that were in force at the start. After that frame ends, it checks that the line stays idle until the enable returns. Filling the queue to capacity is done with the enable held low. This lets the bench try an extra write against a full queue and later count exactly the frames that come out.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even;
        logic       stick;
        logic       two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [CHAR_W-1:0] mask_char(input logic [CHAR_W-1:0] c,
                                                   input logic [1:0] code);
        logic [CHAR_W-1:0] m;
        m = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < int'(word_bits(code)));
        end
        return c & m;
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] masked,
                                       input frame_cfg_t cfg);
        if (cfg.stick) begin
            return ~cfg.even;
        end
        return cfg.even ? (^masked) : ~(^masked);
    endfunction

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single_mode,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              pop,
    output logic [CHAR_W-1:0] pop_data,
    output logic              empty,
    output logic              full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    assign empty    = (count == '0);
    assign full     = single_mode ? !empty : (count == CNT_W'(DEPTH));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              have_char,
    input  logic [CHAR_W-1:0] char_in,
    input  frame_cfg_t        cfg_in,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    tx_state_t         st;
    frame_cfg_t        cfg_q;
    logic [TW-1:0]     tick_cnt;
    logic [3:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_q;
    logic              second_stop;
    logic              bit_end;

    assign take    = (st == ST_IDLE) && en && have_char;
    assign busy    = (st != ST_IDLE);
    assign bit_end = tick && (tick_cnt == TW'(TICKS_PER_BIT-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cfg_q       <= '0;
            tick_cnt    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            par_q       <= 1'b1;
            second_stop <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (take) begin
                st          <= ST_START;
                cfg_q       <= cfg_in;
                shreg       <= mask_char(char_in, cfg_in.wlen);
                par_q       <= parity_of(mask_char(char_in, cfg_in.wlen), cfg_in);
                tick_cnt    <= '0;
                bit_idx     <= '0;
                second_stop <= 1'b0;
            end
        end else begin
            if (tick) begin
                tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            end
            if (bit_end) begin
                case (st)
                    ST_START: begin
                        st      <= ST_DATA;
                        bit_idx <= '0;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == word_bits(cfg_q.wlen) - 4'd1) begin
                            st <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                    ST_PARITY: st <= ST_STOP;
                    ST_STOP: begin
                        if (cfg_q.two_stop && !second_stop) begin
                            second_stop <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (st)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_even,
    input  logic              cfg_stick,
    input  logic              cfg_two_stop,
    input  logic              cfg_fifo_en,
    output logic              full,
    output logic              busy,
    output logic              txd
);
    localparam int CNT_W = $clog2(DEPTH+1);

    frame_cfg_t        cfg_live;
    logic [CHAR_W-1:0] q_data;
    logic              q_empty;
    logic              q_pop;
    logic [CNT_W-1:0]  q_count;

    assign cfg_live = '{wlen: cfg_wlen, par_en: cfg_par_en, even: cfg_even,
                        stick: cfg_stick, two_stop: cfg_two_stop};

    uart_tx_queue #(.DEPTH(DEPTH)) queue_i (
        .clk        (clk),
        .rst        (rst),
        .single_mode(!cfg_fifo_en),
        .push       (wr_en),
        .push_data  (wr_data),
        .pop        (q_pop),
        .pop_data   (q_data),
        .empty      (q_empty),
        .full       (full),
        .count      (q_count)
    );

    uart_tx_serializer #(.TICKS_PER_BIT(TICKS_PER_BIT)) ser_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (baud_tick),
        .have_char(!q_empty),
        .char_in  (q_data),
        .cfg_in   (cfg_live),
        .take     (q_pop),
        .busy     (busy),
        .txd      (txd)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en,
    input logic                       baud_tick,
    input logic                       wr_en,
    input logic                       cfg_fifo_en,
    input logic                       full,
    input logic                       busy,
    input logic                       txd,
    input logic                       q_pop,
    input logic [$clog2(DEPTH+1)-1:0] q_count
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    a_r6_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> ($past(baud_tick) || $rose(busy)));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        q_count <= ($clog2(DEPTH+1))'(DEPTH));

    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !q_pop) |=> (q_count == $past(q_count)));

    a_r9_single_full: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fifo_en && q_count != '0) |-> full);

    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !busy);

    a_r11_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .cfg_fifo_en(cfg_fifo_en),
    .full       (full),
    .busy       (busy),
    .txd        (txd),
    .q_pop      (q_pop),
    .q_count    (q_count)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICKDIV    = 2;
    localparam int TPB        = 16;
    localparam int BIT_CYC    = TPB * TICKDIV;
    localparam int HALF_CYC   = BIT_CYC / 2;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 12;

    // {data[13:6], wlen[5:4], par_en[3], even[2], stick[1], two_stop[0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h3D, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'hE1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h80, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h5A, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h5A, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h0F, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h00, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h96, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic       full, busy, txd;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int busy_run = 0;
    int last_len = 0;
    int tdiv     = 0;

    uart_frame_tx dut_i (
        .clk(clk), .rst(rst), .en(en), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_wlen(cfg_wlen),
        .cfg_par_en(cfg_par_en), .cfg_even(cfg_even), .cfg_stick(cfg_stick),
        .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en),
        .full(full), .busy(busy), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        tdiv   <= (tdiv == TICKDIV-1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == TICKDIV-1);
        if (busy) begin
            busy_run <= busy_run + 1;
        end else if (busy_run != 0) begin
            last_len <= busy_run;
            busy_run <= 0;
        end
    end

    always @(negedge clk) begin
        if (cycles > WATCHDOG) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic ev,
                           input logic sk, input logic ts);
        cfg_wlen = wl; cfg_par_en = pe; cfg_even = ev; cfg_stick = sk; cfg_two_stop = ts;
    endtask

    // mode 0: plain, 1: scramble configuration after start bit, 2: drop enable mid-frame
    task automatic check_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                               input logic ev, input logic sk, input logic ts, input int mode);
        int nb, nbits_total, waited, ones, exp_len;
        logic pbit;
        nb = 5 + int'(wl);
        waited = 0;
        while (txd !== 1'b0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 2000, "R1 start bit seen", waited, 0);
        repeat (HALF_CYC) @(negedge clk);
        check(txd == 1'b0, "R1 start bit low", int'(txd), 0);
        if (mode == 1) set_cfg(~wl, ~pe, ~ev, ~sk, ~ts);
        if (mode == 2) en = 1'b0;
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            ones += int'(d[i]);
            check(txd == d[i], (mode == 1) ? "R7 data bit" : "R2 data bit", int'(txd), int'(d[i]));
        end
        if (pe) begin
            pbit = sk ? ~ev : (ev ? ones[0] : ~ones[0]);
            repeat (BIT_CYC) @(negedge clk);
            check(txd == pbit, sk ? "R4 stick parity" : "R3 parity bit", int'(txd), int'(pbit));
        end
        repeat (BIT_CYC) @(negedge clk);
        check(txd == 1'b1, "R5 first stop", int'(txd), 1);
        if (ts) begin
            repeat (BIT_CYC) @(negedge clk);
            check(txd == 1'b1, "R5 second stop", int'(txd), 1);
        end
        waited = 0;
        while (busy && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        nbits_total = 1 + nb + int'(pe) + (ts ? 2 : 1);
        exp_len = nbits_total * BIT_CYC;
        check((last_len >= exp_len - 2) && (last_len <= exp_len + 2),
              (mode == 2) ? "R10 frame completes" : "R5 R6 R11 frame length", last_len, exp_len);
        if (mode == 1) set_cfg(wl, pe, ev, sk, ts);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        check(busy == 1'b0, "R11 reset busy", int'(busy), 0);
        check(full == 1'b0, "R8 reset full", int'(full), 0);
        rst = 1'b0;
        en  = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VEC[v][5:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
            write_char(VEC[v][13:6]);
            check_frame(VEC[v][13:6], VEC[v][5:4], VEC[v][3], VEC[v][2],
                        VEC[v][1], VEC[v][0], 0);
        end

        // R7: configuration changed after the start bit
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        write_char(8'hC3);
        check_frame(8'hC3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1);

        // R8: fill the FIFO with the enable off, then drain
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        en = 1'b0;
        cfg_fifo_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            write_char(8'(k * 7 + 3));
            if (k == 14) check(full == 1'b0, "R8 not full at 15", int'(full), 0);
        end
        check(full == 1'b1, "R8 full at 16", int'(full), 1);
        write_char(8'hEE);
        check(full == 1'b1, "R8 still full", int'(full), 1);
        repeat (BIT_CYC) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R10 no start while off", int'(busy), 0);
        en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            check_frame(8'(k * 7 + 3), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        end
        repeat (3 * BIT_CYC) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R8 dropped write not sent", int'(busy), 0);

        // R9: single holding register
        en = 1'b0;
        cfg_fifo_en = 1'b0;
        write_char(8'h11);
        check(full == 1'b1, "R9 full with one", int'(full), 1);
        write_char(8'h22);
        en = 1'b1;
        check_frame(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        repeat (3 * BIT_CYC) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R9 second write dropped", int'(busy), 0);
        check(full == 1'b0, "R9 empty after send", int'(full), 0);

        // R10: drop enable mid-frame with a second character queued
        cfg_fifo_en = 1'b1;
        set_cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
        write_char(8'h33);
        write_char(8'h2C);
        check_frame(8'h33, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2);
        repeat (3 * BIT_CYC) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R10 stays idle after finish", int'(busy), 0);
        en = 1'b1;
        check_frame(8'h2C, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule